// File: doc/BRIEF.md
# Linked-Table Address Translation Walker

This block sits between a trace-buffer writer and system memory. It turns each input address into a physical address by looking it up in 4KB page tables that sit in memory. Each table page covers one 1MB window of input space. The last two 64-bit slots of each table page hold links to the neighbouring table pages, so the tables form a chain that can be followed in both directions. Software sets a 1MB-aligned input base and the physical address of the first table page while translation is disabled, and then enables translation.

The walker remembers which table page it currently sits on and that page's window number. For each request it follows forward or backward links one window at a time until it reaches the window the request falls in. It then reads the data entry for the 4KB page and returns the page frame joined with the untouched low twelve address bits. Any entry whose valid flag is clear, or whose reserved bits are set, ends the request with an error. Table entries are read over a simple request/response port, and only one translation is handled at a time.

Top module: `ltw_walker`

## Requirements
- R1: A successful response returns bits [PA_W-1:12] of the data entry as the physical page, with bits [11:0] of the response equal to bits [11:0] of the request address.
- R2: The data entry for a request is read at byte address table_page + 8*idx, where idx is bits [19:12] of (request address minus input base), so data reads touch only slots 0 to 255.
- R3: The window of a request is (request address minus input base) >> 20. When that window is above the current one, the walker reads slot 511 (next link) of the current table page; when it is below, it reads slot 510 (previous link). Each valid link moves the current table page one window in that direction.
- R4: An entry is valid only when bit 0 is 1, bits [11:1] are zero and bits [63:PA_W] are zero. A request that meets an invalid link or data entry receives rsp_err=1 with rsp_addr=0, and the current table page stays the one it was on before that read.
- R5: A request below the input base receives rsp_err=1 and causes no memory read.
- R6: While xlate_en is low, req_ready is low and the walker returns to window 0 at tbl_base.
- R7: Only one request is in flight: after req_ready and req_valid are both high on an edge, req_ready stays low until the response, and req_ready is never high while mem_req_valid is high.
- R8: mem_req_valid stays high with a stable mem_req_addr until mem_req_ready accepts it, and mem_req_addr is always 8-byte aligned.
- R9: Every accepted request gets exactly one response, with rsp_valid high for a single cycle.
- R10: A successful request makes exactly |target window - current window| + 1 memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable; low parks the walker on the first table |
| in_base | input | IN_W | 1MB-aligned input base address |
| tbl_base | input | PA_W | Physical address of the first table page |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_addr | input | IN_W | Input address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Translation failed |
| rsp_addr | output | PA_W | Translated physical address (zero on error) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
The checker watches the handshake rules on every cycle: memory reads stay stable and only go to data or link slots, requests and reads never overlap, responses last one cycle, error responses carry a zero address, a successful address keeps the page offset, and a request below the base makes no read. Whether the right table page was reached, which link direction was taken, how many reads a walk costs, and that a failed link leaves the walker where it was can only be shown by the bench's scenarios. The bench runs a three-page chain with a short last table, a hole in the middle and a bad reserved bit, and checks each case against a behavioural model.

// File: rtl/ltw_pkg.sv
package ltw_pkg;
   localparam int unsigned PAGE_SH   = 12;
   localparam int unsigned WIN_SH    = 20;
   localparam int unsigned ENT_W     = 64;
   localparam int unsigned SLOT_W    = 9;
   localparam logic [SLOT_W-1:0] SLOT_PREV = 9'd510;
   localparam logic [SLOT_W-1:0] SLOT_NEXT = 9'd511;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PLAN,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } ltw_state_e;

   typedef enum logic [1:0] {
      FK_DATA,
      FK_PREV,
      FK_NEXT
   } ltw_fetch_e;
endpackage

// File: rtl/ltw_addr_split.sv
module ltw_addr_split #(
   parameter int unsigned IN_W = 40
) (
   input  logic [IN_W-1:0]                     in_addr,
   input  logic [IN_W-1:0]                     in_base,
   output logic                                below,
   output logic [IN_W-ltw_pkg::WIN_SH-1:0]     win,
   output logic [7:0]                          idx,
   output logic [ltw_pkg::PAGE_SH-1:0]         pgoff
);
   import ltw_pkg::*;

   logic [IN_W-1:0] diff;

   always_comb begin
      diff  = in_addr - in_base;
      below = (in_addr < in_base);
      win   = diff[IN_W-1:WIN_SH];
      idx   = diff[WIN_SH-1:PAGE_SH];
      pgoff = diff[PAGE_SH-1:0];
   end
endmodule

// File: rtl/ltw_entry_dec.sv
module ltw_entry_dec #(
   parameter int unsigned PA_W       = 40,
   parameter bit          STRICT_SBZ = 1'b1
) (
   input  logic [ltw_pkg::ENT_W-1:0]           entry,
   output logic                                valid,
   output logic [PA_W-ltw_pkg::PAGE_SH-1:0]    pfn
);
   import ltw_pkg::*;

   assign pfn = entry[PA_W-1:PAGE_SH];

   generate
      if (STRICT_SBZ) begin : g_strict
         if (PA_W < ENT_W) begin : g_hi
            assign valid = entry[0] && (entry[PAGE_SH-1:1] == '0)
                           && (entry[ENT_W-1:PA_W] == '0);
         end else begin : g_full
            assign valid = entry[0] && (entry[PAGE_SH-1:1] == '0);
         end
      end else begin : g_loose
         assign valid = entry[0];
      end
   endgenerate
endmodule

// File: rtl/ltw_ctrl.sv
module ltw_ctrl #(
   parameter int unsigned IN_W = 40,
   parameter int unsigned PA_W = 40
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en,
   input  logic [PA_W-1:0]               tbl_base,
   input  logic                          req_valid,
   input  logic [IN_W-1:0]               req_addr,
   output logic                          req_ready,
   output logic [IN_W-1:0]               req_q,
   input  logic                          below,
   input  logic [IN_W-ltw_pkg::WIN_SH-1:0] win,
   input  logic [7:0]                    idx,
   input  logic [ltw_pkg::PAGE_SH-1:0]   pgoff,
   output logic                          mem_req_valid,
   input  logic                          mem_req_ready,
   output logic [PA_W-1:0]               mem_req_addr,
   input  logic                          mem_rsp_valid,
   input  logic                          ent_valid,
   input  logic [PA_W-ltw_pkg::PAGE_SH-1:0] ent_pfn,
   output logic                          rsp_valid,
   output logic                          rsp_err,
   output logic [PA_W-1:0]               rsp_addr
);
   import ltw_pkg::*;

   localparam int unsigned WIN_W = IN_W - WIN_SH;
   localparam int unsigned PFN_W = PA_W - PAGE_SH;

   ltw_state_e       state;
   ltw_fetch_e       kind;
   logic [PFN_W-1:0] cur_pfn;
   logic [WIN_W-1:0] cur_win;
   logic [PFN_W-1:0] res_pfn;
   logic [PA_W-1:0]  fetch_addr;
   logic             err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         kind       <= FK_DATA;
         cur_pfn    <= '0;
         cur_win    <= '0;
         res_pfn    <= '0;
         fetch_addr <= '0;
         err_q      <= 1'b0;
         req_q      <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (!en) begin
                  cur_pfn <= tbl_base[PA_W-1:PAGE_SH];
                  cur_win <= '0;
               end else if (req_valid) begin
                  req_q <= req_addr;
                  state <= ST_PLAN;
               end
            end
            ST_PLAN: begin
               if (below) begin
                  err_q <= 1'b1;
                  state <= ST_DONE;
               end else begin
                  err_q <= 1'b0;
                  state <= ST_ISSUE;
                  if (win == cur_win) begin
                     kind       <= FK_DATA;
                     fetch_addr <= {cur_pfn, 1'b0, idx, 3'b000};
                  end else if (win > cur_win) begin
                     kind       <= FK_NEXT;
                     fetch_addr <= {cur_pfn, SLOT_NEXT, 3'b000};
                  end else begin
                     kind       <= FK_PREV;
                     fetch_addr <= {cur_pfn, SLOT_PREV, 3'b000};
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_valid) begin
                     err_q <= 1'b1;
                     state <= ST_DONE;
                  end else begin
                     case (kind)
                        FK_DATA: begin
                           res_pfn <= ent_pfn;
                           state   <= ST_DONE;
                        end
                        FK_NEXT: begin
                           cur_pfn <= ent_pfn;
                           cur_win <= cur_win + 1'b1;
                           state   <= ST_PLAN;
                        end
                        default: begin
                           cur_pfn <= ent_pfn;
                           cur_win <= cur_win - 1'b1;
                           state   <= ST_PLAN;
                        end
                     endcase
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == ST_IDLE) && en;
   assign mem_req_valid = (state == ST_ISSUE);
   assign mem_req_addr  = fetch_addr;
   assign rsp_valid     = (state == ST_DONE);
   assign rsp_err       = err_q;
   assign rsp_addr      = err_q ? '0 : {res_pfn, pgoff};
endmodule

// File: rtl/ltw_walker.sv
module ltw_walker #(
   parameter int unsigned IN_W       = 40,
   parameter int unsigned PA_W       = 40,
   parameter bit          STRICT_SBZ = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            xlate_en,
   input  logic [IN_W-1:0] in_base,
   input  logic [PA_W-1:0] tbl_base,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [IN_W-1:0] req_addr,
   output logic            rsp_valid,
   output logic            rsp_err,
   output logic [PA_W-1:0] rsp_addr,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [63:0]     mem_rsp_data
);
   import ltw_pkg::*;

   localparam int unsigned WIN_W = IN_W - WIN_SH;
   localparam int unsigned PFN_W = PA_W - PAGE_SH;

   generate
      if (IN_W <= WIN_SH) begin : g_bad_in
         $error("IN_W must exceed the window shift");
      end
      if (PA_W <= WIN_SH || PA_W > ENT_W) begin : g_bad_pa
         $error("PA_W must lie above the window shift and within an entry");
      end
   endgenerate

   logic [IN_W-1:0]    req_q;
   logic               below;
   logic [WIN_W-1:0]   win;
   logic [7:0]         idx;
   logic [PAGE_SH-1:0] pgoff;
   logic               ent_valid;
   logic [PFN_W-1:0]   ent_pfn;

   ltw_addr_split #(.IN_W(IN_W)) u_split (
      .in_addr (req_q),
      .in_base (in_base),
      .below   (below),
      .win     (win),
      .idx     (idx),
      .pgoff   (pgoff)
   );

   ltw_entry_dec #(.PA_W(PA_W), .STRICT_SBZ(STRICT_SBZ)) u_dec (
      .entry (mem_rsp_data),
      .valid (ent_valid),
      .pfn   (ent_pfn)
   );

   ltw_ctrl #(.IN_W(IN_W), .PA_W(PA_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (xlate_en),
      .tbl_base      (tbl_base),
      .req_valid     (req_valid),
      .req_addr      (req_addr),
      .req_ready     (req_ready),
      .req_q         (req_q),
      .below         (below),
      .win           (win),
      .idx           (idx),
      .pgoff         (pgoff),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .ent_valid     (ent_valid),
      .ent_pfn       (ent_pfn),
      .rsp_valid     (rsp_valid),
      .rsp_err       (rsp_err),
      .rsp_addr      (rsp_addr)
   );
endmodule

// File: rtl/ltw_walker_chk.sv
module ltw_walker_chk #(
   parameter int unsigned IN_W = 40,
   parameter int unsigned PA_W = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            xlate_en,
   input logic [IN_W-1:0] in_base,
   input logic            req_valid,
   input logic            req_ready,
   input logic [IN_W-1:0] req_addr,
   input logic            rsp_valid,
   input logic            rsp_err,
   input logic [PA_W-1:0] rsp_addr,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr
);
   logic [11:0] off_cap;
   logic        low_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_cap  <= '0;
         low_pend <= 1'b0;
      end else if (req_valid && req_ready) begin
         off_cap  <= req_addr[11:0];
         low_pend <= (req_addr < in_base);
      end else if (rsp_valid) begin
         low_pend <= 1'b0;
      end
   end

   assert_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> (rsp_addr[11:0] == off_cap));

   assert_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[11:3] < 9'd256 || mem_req_addr[11:3] >= 9'd510));

   assert_errzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_addr == '0));

   assert_noread_R5: assert property (@(posedge clk) disable iff (!rst_n)
      low_pend |-> !mem_req_valid);

   assert_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xlate_en |-> !req_ready);

   assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && mem_req_valid));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

   assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind ltw_walker ltw_walker_chk #(.IN_W(IN_W), .PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .xlate_en      (xlate_en),
   .in_base       (in_base),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .rsp_valid     (rsp_valid),
   .rsp_err       (rsp_err),
   .rsp_addr      (rsp_addr),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_ltw_walker.sv
module sim_ltw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlate_en = 1'b0;
   logic [39:0] in_base = 40'h00_4010_0000;
   logic [39:0] tbl_base = 40'h00_2000_0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [39:0] req_addr = '0;
   logic        rsp_valid, rsp_err;
   logic [39:0] rsp_addr;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [39:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;

   ltw_walker u0 (.*);

   always #10 clk = ~clk;

   int nchk = 0, nerr = 0, reads = 0, pulses = 0, nreq = 0, cyc = 0;
   bit done = 1'b0;
   logic [63:0] mem [logic [39:0]];
   logic [39:0] tbl [3] = '{40'h00_2000_0000, 40'h00_2000_5000, 40'h00_2000_3000};
   logic [39:0] m_tbl;
   int          m_win;
   int unsigned lcg = 32'h1234_5678;

   // memory responder with random stalls and latency
   bit          pend = 1'b0;
   int          lat = 0;
   logic [63:0] pdata;

   function automatic logic [63:0] rd(input logic [39:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      mem_req_ready <= ($urandom % 3) != 0;
      if (rsp_valid) pulses <= pulses + 1;
      if (pend) begin
         if (lat == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= pdata;
            pend <= 1'b0;
         end else lat <= lat - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
         pend  <= 1'b1;
         lat   <= $urandom % 3;
         pdata <= rd(mem_req_addr);
         reads <= reads + 1;
      end
   end

   always @(posedge clk) begin
      if (cyc == 150000 && !done) begin
         nerr++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit ent_ok(input logic [63:0] e);
      return e[0] && (e[11:1] == 0) && (e[63:40] == 0);
   endfunction

   // behavioural model of one translation
   task automatic model(input logic [39:0] a, output bit err, output logic [39:0] pa,
                        output int nrd);
      longint tw;
      logic [39:0] d;
      logic [63:0] e;
      nrd = 0; err = 1'b0; pa = '0;
      if (a < in_base) begin err = 1'b1; return; end
      d  = a - in_base;
      tw = longint'(d >> 20);
      forever begin
         if (tw == m_win) begin
            e = rd(m_tbl + {28'd0, d[19:12], 3'b000});
            nrd++;
            if (ent_ok(e)) pa = {e[39:12], a[11:0]}; else err = 1'b1;
            return;
         end
         e = rd(m_tbl + ((tw > m_win) ? 40'd4088 : 40'd4080));
         nrd++;
         if (!ent_ok(e)) begin err = 1'b1; return; end
         m_tbl = {e[39:12], 12'h000};
         m_win += (tw > m_win) ? 1 : -1;
      end
   endtask

   task automatic do_req(input logic [39:0] a, input string tag);
      bit e; logic [39:0] pa; int nrd; int w;
      model(a, e, pa, nrd);
      @(negedge clk);
      reads = 0;
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      nreq++;
      w = 0;
      while (!rsp_valid && w < 2000) begin @(negedge clk); w++; end
      chk({tag, " R9 response seen"}, 64'(rsp_valid), 64'd1);
      chk({tag, " R4 error flag"}, 64'(rsp_err), 64'(e));
      chk({tag, " R1 address"}, 64'(rsp_addr), 64'(pa));
      if (!e) chk({tag, " R10 read count"}, 64'(reads), 64'(nrd));
      else    chk({tag, " R5 read count"}, 64'(reads), 64'(nrd));
      @(negedge clk);
      chk({tag, " R9 single pulse"}, 64'(rsp_valid), 64'd0);
   endtask

   function automatic logic [39:0] ia(input int w, input int i, input int o);
      return in_base + (40'(w) << 20) + (40'(i) << 12) + 40'(o);
   endfunction

   initial begin
      for (int w = 0; w < 3; w++) begin
         for (int i = 0; i < ((w == 2) ? 100 : 256); i++)
            mem[tbl[w] + 40'(i * 8)] = {24'd0, 40'h09_0000_0000 + 40'((w * 256 + i) * 32'h3000)} | 64'h1;
         mem[tbl[w] + 40'd4080] = (w > 0) ? {24'd0, tbl[w-1]} | 64'h1 : 64'h0;
         mem[tbl[w] + 40'd4088] = (w < 2) ? {24'd0, tbl[w+1]} | 64'h1 : 64'h0;
      end
      mem.delete(tbl[1] + 40'd56);              // hole at window 1 entry 7
      mem[tbl[0] + 40'd72] = mem[tbl[0] + 40'd72] | 64'h20;  // reserved bit set
      m_tbl = tbl_base; m_win = 0;

      repeat (3) @(negedge clk);
      chk("R7 reset req_ready", 64'(req_ready), 64'd0);
      chk("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R8 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 parked req_ready", 64'(req_ready), 64'd0);
      xlate_en = 1'b1;
      @(negedge clk);
      chk("R7 idle req_ready", 64'(req_ready), 64'd1);

      do_req(ia(0, 0, 12'h123), "R1 first page");
      do_req(ia(2, 5, 12'h7f8), "R3 two next links");
      do_req(ia(1, 3, 12'h004), "R3 prev link");
      do_req(ia(1, 7, 12'h010), "R4 invalid data entry");
      do_req(ia(3, 0, 12'h000), "R4 missing next link");
      do_req(ia(2, 99, 12'hfff), "R4 table unchanged after link fail");
      do_req(ia(2, 150, 12'h0), "R4 unused tail entry");
      do_req(in_base - 40'h80, "R5 below base");
      do_req(ia(0, 9, 12'h0), "R4 reserved bits set");
      do_req(ia(0, 255, 12'hab0), "R2 last data slot");

      @(negedge clk);
      xlate_en = 1'b0;
      m_tbl = tbl_base; m_win = 0;
      repeat (3) @(negedge clk);
      chk("R6 disabled req_ready", 64'(req_ready), 64'd0);
      xlate_en = 1'b1;
      do_req(ia(0, 1, 12'h0), "R6 restart at window 0");

      for (int k = 0; k < 30; k++) begin
         int w, i, o;
         lcg = lcg * 32'd1103515245 + 32'd12345; w = int'((lcg >> 8) % 4);
         lcg = lcg * 32'd1103515245 + 32'd12345; i = int'((lcg >> 8) % 256);
         lcg = lcg * 32'd1103515245 + 32'd12345; o = int'((lcg >> 8) % 4096);
         do_req(ia(w, i, o), "R2 mixed walk");
      end

      @(negedge clk);
      chk("R9 pulse total", 64'(pulses), 64'(nreq));
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule